// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and reduces them to two processor interrupt outputs. The fast output carries the urgent level and the normal output carries the other. Firmware chooses a level for each channel and enables each channel on its own. For each level the block also presents a vector index that names the winning channel. A handler uses that index as an offset into its table of service routines.

Requests are sampled every clock into a pending register. A pending bit drops when its source lowers the request. Firmware can also drop it by writing a one to the clear register, which is normally the first thing a handler does. A cleared channel stays quiet while its request line remains high. It can raise a new interrupt only after the line has gone low and come back. Among enabled pending channels on one level, the highest-numbered channel wins.

A small register port carries the configuration and the read-back. A write takes effect at the clock edge on which the write strobe is high. Read data is a combinational function of the address.

Top module: `intc_top`

## Requirements
- R1: While reset is asserted and right after it, every enable bit is 0 and every level bit is 0 (all channels route to the normal level). Both outputs are low, nothing is pending, and both vector indices read the "none" code 0x20.
- R2: Bit k of the pending register (read at address 2) becomes 1 on the clock edge at which `irq_req_i[k]` is high, provided channel k is not cleared. It becomes 0 on the first edge at which the request is low.
- R3: `fiq_o` (`irq_o`) is high in the cycle after an edge at which some channel was pending, enabled and routed to the fast (normal) level. Otherwise it is low.
- R4: A channel whose enable bit (address 0, bit k) is 0 never raises an output and never appears in a vector index, even while it is pending.
- R5: Level bit k (address 1) set to 1 routes channel k to the fast level and set to 0 routes it to the normal level. A channel counts toward exactly one level.
- R6: A vector index is {1'b0, k}, where k is the highest-numbered channel that is pending, enabled and routed to that level. Channel 0 alone gives 0x00. The index follows the registered state in the same cycle.
- R7: When no channel qualifies on a level, that level's vector reads 0x20 (bit 5 set, bits 4:0 zero).
- R8: Writing a 1 to bit k of address 2 clears pending bit k at that edge. The bit stays clear while the request remains high and re-arms once the request has been low for one edge. The next highest qualifying channel shows in the vector in the following cycle.
- R9: Register map: address 0 enables (read/write), 1 level select (read/write), 2 pending (read) and clear (write 1). Address 3 is the fast vector and address 4 the normal vector, both read-only and zero-extended. Other addresses read 0, and writes to 3 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 32 | Level-sensitive request lines, channel k on bit k |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| fiq_o | output | 1 | Fast-level interrupt, registered |
| irq_o | output | 1 | Normal-level interrupt, registered |
| fiq_vec_o | output | 6 | Fast-level vector index, 0x20 when none |
| irq_vec_o | output | 6 | Normal-level vector index, 0x20 when none |

## Verification
The bench drives all channels at once with nothing enabled. A design that leaks masked channels would then raise an output or report channel 31. Channel 0 standing alone has to give index 0x00 rather than the none code; an encoder that conflates "index zero" with "nothing" fails that case. The bench clears the top channels while their requests stay high, which catches a design that simply re-samples the request and lets the channel return at once. It then drops and re-raises the request to confirm the re-arm. A random phase moving enables, levels and clears under sparse requests exposes off-by-one-cycle output timing and ties between the two levels.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned DEF_NCH = 32;

    typedef enum logic [2:0] {
        A_ENABLE = 3'd0,
        A_LEVEL  = 3'd1,
        A_PEND   = 3'd2,
        A_FVEC   = 3'd3,
        A_NVEC   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2:0]     addr,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] enable_o,
    output logic [NCH-1:0] level_o,
    output logic [NCH-1:0] clr_o
);
    logic [NCH-1:0] enable_q;
    logic [NCH-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            level_q  <= '0;
        end else if (we) begin
            if (addr == A_ENABLE) enable_q <= wdata;
            if (addr == A_LEVEL)  level_q  <= wdata;
        end
    end

    always_comb begin
        clr_o = '0;
        if (we && addr == A_PEND) clr_o = wdata;
    end

    assign enable_o = enable_q;
    assign level_o  = level_q;
endmodule

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] pend_o
);
    // acked_q marks channels cleared by firmware whose request is still high
    logic [NCH-1:0] acked_q;
    logic [NCH-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acked_q <= '0;
            pend_q  <= '0;
        end else begin
            acked_q <= req_i & (acked_q | clr_i);
            pend_q  <= req_i & ~(acked_q | clr_i);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int unsigned NCH  = DEF_NCH,
    localparam int unsigned IDXW = $clog2(NCH),
    localparam int unsigned VECW = IDXW + 1
) (
    input  logic [NCH-1:0]  act_i,
    output logic [VECW-1:0] vec_o
);
    typedef logic [IDXW-1:0] idx_t;

    // ascending scan: the last hit, the highest channel, wins
    always_comb begin
        vec_o = {1'b1, {IDXW{1'b0}}};
        for (int i = 0; i < NCH; i++) begin
            if (act_i[i]) vec_o = {1'b0, idx_t'(i)};
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    localparam int unsigned IDXW = $clog2(NCH),
    localparam int unsigned VECW = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  irq_req_i,
    input  logic            bus_we,
    input  logic [2:0]      bus_addr,
    input  logic [NCH-1:0]  bus_wdata,
    output logic [NCH-1:0]  bus_rdata,
    output logic            fiq_o,
    output logic            irq_o,
    output logic [VECW-1:0] fiq_vec_o,
    output logic [VECW-1:0] irq_vec_o
);
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] level_q;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] pend_q;
    logic [1:0][NCH-1:0]  act;
    logic [1:0][VECW-1:0] vec;
    logic fiq_q;
    logic irq_q;

    intc_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .enable_o (mask_q),
        .level_o  (level_q),
        .clr_o    (clr)
    );

    intc_pending #(.NCH(NCH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req_i),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    // index 1 is the fast level, index 0 the normal level
    for (genvar g = 0; g < 2; g++) begin : g_lvl
        if (g == 1) begin : g_fast
            assign act[g] = pend_q & mask_q & level_q;
        end else begin : g_norm
            assign act[g] = pend_q & mask_q & ~level_q;
        end
        intc_prio #(.NCH(NCH)) u_prio (
            .act_i (act[g]),
            .vec_o (vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            fiq_q <= |act[1];
            irq_q <= |act[0];
        end
    end

    assign fiq_o     = fiq_q;
    assign irq_o     = irq_q;
    assign fiq_vec_o = vec[1];
    assign irq_vec_o = vec[0];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata = mask_q;
            A_LEVEL:  bus_rdata = level_q;
            A_PEND:   bus_rdata = pend_q;
            A_FVEC:   bus_rdata = {{(NCH-VECW){1'b0}}, vec[1]};
            A_NVEC:   bus_rdata = {{(NCH-VECW){1'b0}}, vec[0]};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int unsigned NCH  = DEF_NCH,
    parameter int unsigned VECW = $clog2(NCH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  req_i,
    input logic            bus_we,
    input logic [2:0]      bus_addr,
    input logic [NCH-1:0]  bus_wdata,
    input logic [NCH-1:0]  pend,
    input logic [NCH-1:0]  mask,
    input logic [NCH-1:0]  level,
    input logic            fiq,
    input logic            irq,
    input logic [VECW-1:0] fiq_vec,
    input logic [VECW-1:0] irq_vec
);
    localparam logic [VECW-1:0] NONE = {1'b1, {(VECW-1){1'b0}}};

    p_pend_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(req_i)) == '0);

    p_fast_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fiq == $past(|(pend & mask & level)));

    p_norm_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(pend & mask & ~level)));

    p_fast_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_vec[VECW-1] |-> (mask[fiq_vec[VECW-2:0]] && pend[fiq_vec[VECW-2:0]]));

    p_norm_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vec[VECW-1] |-> (mask[irq_vec[VECW-2:0]] && pend[irq_vec[VECW-2:0]]));

    p_one_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiq_vec[VECW-1] && !irq_vec[VECW-1]) |-> fiq_vec != irq_vec);

    p_fast_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_vec[VECW-1] |-> ((pend & mask & level) >> fiq_vec[VECW-2:0]) == NCH'(1));

    p_norm_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vec[VECW-1] |-> ((pend & mask & ~level) >> irq_vec[VECW-2:0]) == NCH'(1));

    p_fast_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask & level) == '0) |-> fiq_vec == NONE);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND) |=> (pend & $past(bus_wdata)) == '0);
endmodule

bind intc_top intc_chk #(.NCH(NCH), .VECW(VECW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (irq_req_i),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (pend_q),
    .mask      (mask_q),
    .level     (level_q),
    .fiq       (fiq_o),
    .irq       (irq_o),
    .fiq_vec   (fiq_vec_o),
    .irq_vec   (irq_vec_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;
    logic [5:0]  fvec, nvec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mask = '0, m_lvl = '0, m_ack = '0, m_pend = '0;
    logic        m_fiq = 1'b0, m_irq = 1'b0;

    always #10 clk = ~clk;

    intc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (req),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .fiq_o     (fiq),
        .irq_o     (irq),
        .fiq_vec_o (fvec),
        .irq_vec_o (nvec)
    );

    function automatic logic [5:0] ref_vec(logic [31:0] a);
        logic [5:0] v = 6'h20;
        for (int i = 0; i < 32; i++) if (a[i]) v = {1'b0, 5'(i)};
        return v;
    endfunction

    function automatic logic [31:0] ref_rd(logic [2:0] a);
        case (a)
            3'd0: return m_mask;
            3'd1: return m_lvl;
            3'd2: return m_pend;
            3'd3: return {26'b0, ref_vec(m_pend & m_mask & m_lvl)};
            3'd4: return {26'b0, ref_vec(m_pend & m_mask & ~m_lvl)};
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: update the model at the edge, compare at the falling edge
    task automatic cyc();
        logic [31:0] clr;
        @(posedge clk);
        clr = (we && addr == 3'd2) ? wdata : '0;
        m_fiq  = |(m_pend & m_mask & m_lvl);
        m_irq  = |(m_pend & m_mask & ~m_lvl);
        m_pend = req & ~(m_ack | clr);
        m_ack  = req & (m_ack | clr);
        if (we && addr == 3'd0) m_mask = wdata;
        if (we && addr == 3'd1) m_lvl  = wdata;
        @(negedge clk);
        we = 1'b0;
        chk("R3", "fiq_o", {31'b0, fiq}, {31'b0, m_fiq});
        chk("R3", "irq_o", {31'b0, irq}, {31'b0, m_irq});
        chk("R6", "fiq_vec", {26'b0, fvec}, {26'b0, ref_vec(m_pend & m_mask & m_lvl)});
        chk("R6", "irq_vec", {26'b0, nvec}, {26'b0, ref_vec(m_pend & m_mask & ~m_lvl)});
        chk("R9", "rdata", rdata, ref_rd(addr));
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "fiq_o", {31'b0, fiq}, 32'd0);
        chk("R1", "irq_o", {31'b0, irq}, 32'd0);
        chk("R1", "fiq_vec", {26'b0, fvec}, 32'h20);
        chk("R1", "irq_vec", {26'b0, nvec}, 32'h20);
        addr = 3'd0; #1 chk("R1", "enable", rdata, 32'd0);
        addr = 3'd1; #1 chk("R1", "level", rdata, 32'd0);
        addr = 3'd2; #1 chk("R1", "pending", rdata, 32'd0);
        rst_n = 1'b1;
        cyc();

        // R4: everything requested, nothing enabled
        req = '1;
        cyc(); cyc();
        chk("R4", "irq_o masked", {31'b0, irq}, 32'd0);
        chk("R7", "irq_vec none", {26'b0, nvec}, 32'h20);

        // R6: all enabled on the normal level, 31 wins
        wr(3'd0, '1);
        chk("R6", "irq_vec top", {26'b0, nvec}, 32'd31);
        cyc();
        chk("R3", "irq_o high", {31'b0, irq}, 32'd1);

        // R5: move channel 31 to the fast level
        wr(3'd1, 32'h8000_0000);
        chk("R5", "fiq_vec", {26'b0, fvec}, 32'd31);
        chk("R5", "irq_vec", {26'b0, nvec}, 32'd30);

        // R8: clear 31 and 30 while requests stay high
        wr(3'd2, 32'hC000_0000);
        chk("R8", "fiq_vec after clear", {26'b0, fvec}, 32'h20);
        chk("R8", "irq_vec next", {26'b0, nvec}, 32'd29);
        cyc(); cyc();
        chk("R8", "stays cleared", {26'b0, fvec}, 32'h20);
        req[31] = 1'b0; cyc();
        req[31] = 1'b1; cyc();
        chk("R8", "re-armed", {26'b0, fvec}, 32'd31);

        // R2 and R6: a lone channel 0
        req = '0; addr = 3'd2; cyc();
        chk("R2", "pending drops", rdata, 32'd0);
        req = 32'd1; cyc();
        chk("R2", "pending set", rdata, 32'd1);
        chk("R6", "irq_vec ch0", {26'b0, nvec}, 32'd0);
        chk("R3", "irq_o not yet", {31'b0, irq}, 32'd0);
        cyc();
        chk("R3", "irq_o next", {31'b0, irq}, 32'd1);

        // R9: writes to a vector address change nothing
        wr(3'd3, '1);
        addr = 3'd0; #1 chk("R9", "enable kept", rdata, 32'hFFFF_FFFF);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            req = $urandom & $urandom & $urandom;
            addr = 3'($urandom_range(0, 5));
            if ($urandom_range(0, 7) == 0) begin
                we = 1'b1;
                addr = 3'($urandom_range(0, 3));
                wdata = $urandom;
            end
            cyc();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule